// File: doc/BRIEF.md
# Whole-Word Triple-Redundancy Voter with Disagreement Flag

This block sits behind three replicated copies of a logic function and reduces their three result words to one. It treats each result as a single word and looks for any pair that matches exactly. When a pair matches, that word goes to the output, which hides one broken copy. When no pair matches, the block raises an error flag instead of building a bitwise-majority word. A bitwise vote can produce a word that none of the copies computed. A word vote cannot.

A mode input states that the second copy delivers its result inverted. In that mode the block complements that copy before it compares the words. A three-bit disagreement vector marks each copy whose word differs from the voted word, so a supervisor can tell which copy is failing. A parameter chooses between a purely combinational result and a registered result. The registered form has a synchronous active-high reset.

Top module: `word_vote_tmr`

## Requirements
- R1: Words are compared whole. For the replica words 2'b10, 2'b11 and 2'b01, held in the two low bits with the upper bits zero, the error flag is high. A bitwise majority vote would have given 2'b11 for this set.
- R2: When all three replica words are equal, the output is that word and the error flag is low.
- R3: When exactly two replica words are equal, the output is the shared word and the error flag is low. This holds for each of the pairs A-B, A-C and B-C.
- R4: When no two replica words are equal, the error flag is high.
- R5: While the error flag is high, the output carries replica A's word.
- R6: When `rep_b_inv` is 1, replica B is complemented before any comparison and before it can be selected. When `rep_b_inv` is 0, replica B is used exactly as received.
- R7: In `disagree_o`, bit 0 stands for replica A, bit 1 for replica B (after R6 alignment) and bit 2 for replica C. A bit is 1 exactly when that replica's word differs from the output word. When the error flag is high the vector is 3'b110.
- R8: With `REGISTER_OUT`=1 (the default), the output word, the error flag and the disagreement vector appear one clock after the inputs that produced them are sampled.
- R9: With `REGISTER_OUT`=1, a clock edge with `rst` high clears the output word, the error flag and the disagreement vector to zero, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| rep_b_inv | input | 1 | 1: replica B arrives complemented |
| rep_a | input | WIDTH | Result word of replica A |
| rep_b | input | WIDTH | Result word of replica B |
| rep_c | input | WIDTH | Result word of replica C |
| voted_o | output | WIDTH | Voted word |
| error_o | output | 1 | No two replica words agree |
| disagree_o | output | 3 | Per-replica mismatch against the voted word |

## Verification
The hardest case to reach is a set of three mutually different words for which a bitwise majority still yields a plausible word. Random words give an error on almost every vector and almost never give a match. The bench therefore drives the two-bit case directly. Its random phase draws a pattern class first (all equal, each pair, all different) and then builds the words from that class. The complement mode is hardest where raw words that look equal become unequal after alignment, or the reverse. Directed vectors feed the same raw words with the mode off and then on, so that the effect of the mode shows on the voted output.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;

    // Number of replicas and number of distinct replica pairs.
    localparam int NUM_REP  = 3;
    localparam int NUM_PAIR = 3;

    // Replica index positions inside word arrays and the mismatch vector.
    localparam int IDX_A = 0;
    localparam int IDX_B = 1;
    localparam int IDX_C = 2;

    // Pair index positions inside the equality vector.
    localparam int PAIR_AB = 0;
    localparam int PAIR_AC = 1;
    localparam int PAIR_BC = 2;

    // Outcome of the vote.
    typedef enum logic [1:0] {
        PICK_A   = 2'd0,
        PICK_B   = 2'd1,
        PICK_ERR = 2'd2
    } vote_pick_e;

    // Lower replica index of a pair.
    function automatic int pair_lo(input int p);
        return (p == PAIR_BC) ? IDX_B : IDX_A;
    endfunction

    // Upper replica index of a pair.
    function automatic int pair_hi(input int p);
        return (p == PAIR_AB) ? IDX_B : IDX_C;
    endfunction

endpackage

// File: rtl/tmr_rep_align.sv
// Undoes the inversion of a replica that delivers its result complemented.
module tmr_rep_align #(
    parameter int WIDTH = 8
) (
    input  logic             inv_en,
    input  logic [WIDTH-1:0] raw_word,
    output logic [WIDTH-1:0] aligned_word
);

    logic [WIDTH-1:0] flip_mask;

    always_comb begin
        flip_mask    = {WIDTH{inv_en}};
        aligned_word = raw_word ^ flip_mask;
    end

    // R6: an aligned word equals the raw word or its complement, never anything else
    always_comb begin
        assert ((aligned_word == raw_word) || (aligned_word == ~raw_word))
            else $error("p_align_shape_r6 violated");
    end

endmodule

// File: rtl/tmr_word_eq.sv
// Full-word equality of two replica results.
module tmr_word_eq #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] word_x,
    input  logic [WIDTH-1:0] word_y,
    output logic             same
);

    logic [WIDTH-1:0] diff_bits;

    always_comb begin
        diff_bits = word_x ^ word_y;
        same      = (diff_bits == '0);
    end

endmodule

// File: rtl/tmr_vote_select.sv
// Turns the pairwise equality flags into the voted word, the error flag and the
// per-replica mismatch vector.
module tmr_vote_select
    import tmr_vote_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]    words [NUM_REP],
    input  logic [NUM_PAIR-1:0] pair_same,
    output vote_pick_e          pick,
    output logic [WIDTH-1:0]    vote_word,
    output logic                no_pair,
    output logic [NUM_REP-1:0]  mismatch
);

    always_comb begin
        if (pair_same[PAIR_AB] || pair_same[PAIR_AC]) begin
            pick = PICK_A;
        end else if (pair_same[PAIR_BC]) begin
            pick = PICK_B;
        end else begin
            pick = PICK_ERR;
        end
    end

    always_comb begin
        no_pair = 1'b0;
        case (pick)
            PICK_A:   vote_word = words[IDX_A];
            PICK_B:   vote_word = words[IDX_B];
            default: begin
                vote_word = words[IDX_A];
                no_pair   = 1'b1;
            end
        endcase
    end

    for (genvar r = 0; r < NUM_REP; r++) begin : g_mismatch
        always_comb begin
            mismatch[r] = (words[r] != vote_word);
        end
    end

    // R4: the error outcome never coexists with any matching pair of words
    always_comb begin
        if (no_pair) begin
            assert ((words[IDX_A] != words[IDX_B]) && (words[IDX_A] != words[IDX_C])
                    && (words[IDX_B] != words[IDX_C]))
                else $error("p_err_only_all_differ_r4 violated");
        end
    end

    // R3: a non-error outcome leaves at least two replicas agreeing with the vote
    always_comb begin
        if (!no_pair) begin
            assert ($countones(mismatch) <= 1)
                else $error("p_majority_agrees_r3 violated");
        end
    end

endmodule

// File: rtl/word_vote_tmr.sv
module word_vote_tmr
    import tmr_vote_pkg::*;
#(
    parameter int WIDTH        = 8,
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rep_b_inv,
    input  logic [WIDTH-1:0] rep_a,
    input  logic [WIDTH-1:0] rep_b,
    input  logic [WIDTH-1:0] rep_c,
    output logic [WIDTH-1:0] voted_o,
    output logic             error_o,
    output logic [2:0]       disagree_o
);

    typedef struct packed {
        logic [WIDTH-1:0]   vote;
        logic               err;
        logic [NUM_REP-1:0] dis;
    } vote_out_t;

    logic [WIDTH-1:0]    words [NUM_REP];
    logic [WIDTH-1:0]    rep_b_aligned;
    logic [NUM_PAIR-1:0] pair_same;
    vote_pick_e          pick;
    logic [WIDTH-1:0]    sel_word;
    logic                sel_err;
    logic [NUM_REP-1:0]  sel_dis;
    vote_out_t           out_d;
    vote_out_t           out_q;

    tmr_rep_align #(.WIDTH(WIDTH)) u_align_b (
        .inv_en       (rep_b_inv),
        .raw_word     (rep_b),
        .aligned_word (rep_b_aligned)
    );

    always_comb begin
        words[IDX_A] = rep_a;
        words[IDX_B] = rep_b_aligned;
        words[IDX_C] = rep_c;
    end

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        localparam int LO = pair_lo(p);
        localparam int HI = pair_hi(p);
        tmr_word_eq #(.WIDTH(WIDTH)) u_eq (
            .word_x (words[LO]),
            .word_y (words[HI]),
            .same   (pair_same[p])
        );
    end

    tmr_vote_select #(.WIDTH(WIDTH)) u_select (
        .words     (words),
        .pair_same (pair_same),
        .pick      (pick),
        .vote_word (sel_word),
        .no_pair   (sel_err),
        .mismatch  (sel_dis)
    );

    always_comb begin
        out_d      = '0;
        out_d.vote = sel_word;
        out_d.err  = sel_err;
        out_d.dis  = sel_dis;
    end

    if (REGISTER_OUT) begin : g_reg
        logic hist_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                out_q  <= '0;
                hist_q <= 1'b0;
            end else begin
                out_q  <= out_d;
                hist_q <= 1'b1;
            end
        end

        // R9: the first edge after a reset edge shows cleared outputs
        p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (voted_o == '0 && !error_o && disagree_o == '0));

        // R2: three equal words pass through one cycle later with no error
        p_all_equal_r2: assert property (@(posedge clk) disable iff (rst)
            (hist_q && $past(rep_a == rep_c && rep_a == (rep_b_inv ? ~rep_b : rep_b)))
            |-> (voted_o == $past(rep_a) && !error_o));

        // R3: a matching A-C pair is delivered one cycle later without error
        p_pair_ac_pass_r3: assert property (@(posedge clk) disable iff (rst)
            (hist_q && $past(rep_a == rep_c)) |-> (voted_o == $past(rep_a) && !error_o));

        // R5: an error cycle carries replica A's sampled word
        p_err_gives_a_r5: assert property (@(posedge clk) disable iff (rst)
            (hist_q && error_o) |-> (voted_o == $past(rep_a)));

        // R7: while in error, only replicas B and C are marked
        p_err_marks_bc_r7: assert property (@(posedge clk) disable iff (rst)
            error_o |-> (disagree_o == 3'b110));

        // R8: outputs move only one cycle after an input change
        p_latency_r8: assert property (@(posedge clk) disable iff (rst)
            (hist_q && $stable(rep_a) && $stable(rep_b) && $stable(rep_c)
             && $stable(rep_b_inv) && $past(hist_q))
            |=> ($stable(voted_o) && $stable(error_o)));
    end else begin : g_comb
        always_comb begin
            out_q = out_d;
        end
    end

    always_comb begin
        voted_o    = out_q.vote;
        error_o    = out_q.err;
        disagree_o = out_q.dis;
    end

endmodule

// File: tb/word_vote_tmr_tb.sv
module word_vote_tmr_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rep_b_inv = 1'b0;
    logic [W-1:0] rep_a = '0;
    logic [W-1:0] rep_b = '0;
    logic [W-1:0] rep_c = '0;
    logic [W-1:0] voted_o;
    logic         error_o;
    logic [2:0]   disagree_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [W-1:0] q_vote [$];
    logic         q_err  [$];
    logic [2:0]   q_dis  [$];
    string        q_tag  [$];

    always #4 clk = ~clk;

    word_vote_tmr #(.WIDTH(W), .REGISTER_OUT(1'b1)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .rep_b_inv  (rep_b_inv),
        .rep_a      (rep_a),
        .rep_b      (rep_b),
        .rep_c      (rep_c),
        .voted_o    (voted_o),
        .error_o    (error_o),
        .disagree_o (disagree_o)
    );

    // Behavioural reference: first pair found equal decides, else error with A.
    task automatic ref_vote(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [W-1:0] c, input logic inv,
                            output logic [W-1:0] v, output logic e,
                            output logic [2:0] d);
        logic [W-1:0] w [3];
        bit found;
        w[0] = a;
        w[1] = inv ? ~b : b;
        w[2] = c;
        found = 1'b0;
        v = a;
        for (int i = 0; i < 3; i++) begin
            for (int j = i + 1; j < 3; j++) begin
                if (!found && w[i] == w[j]) begin
                    v = w[i];
                    found = 1'b1;
                end
            end
        end
        e = !found;
        for (int k = 0; k < 3; k++) d[k] = (w[k] != v);
    endtask

    task automatic check_pending();
        logic [W-1:0] ev;
        logic ee;
        logic [2:0] ed;
        string t;
        if (q_vote.size() == 0) return;
        ev = q_vote.pop_front();
        ee = q_err.pop_front();
        ed = q_dis.pop_front();
        t  = q_tag.pop_front();
        compared++;
        if (voted_o !== ev || error_o !== ee || disagree_o !== ed) begin
            mismatched++;
            $display("FAIL %s: got vote=%h err=%b dis=%b, expected vote=%h err=%b dis=%b",
                     t, voted_o, error_o, disagree_o, ev, ee, ed);
        end
    endtask

    // One cycle: check the result of the previous cycle, then drive new inputs.
    task automatic step(input logic r, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] c, input logic inv, input string tag);
        logic [W-1:0] v;
        logic e;
        logic [2:0] d;
        @(negedge clk);
        check_pending();
        rst = r;
        rep_a = a;
        rep_b = b;
        rep_c = c;
        rep_b_inv = inv;
        if (r) begin
            v = '0; e = 1'b0; d = '0;
        end else begin
            ref_vote(a, b, c, inv, v, e, d);
        end
        q_vote.push_back(v);
        q_err.push_back(e);
        q_dis.push_back(d);
        q_tag.push_back(tag);
    endtask

    initial begin
        // R9: reset clears outputs despite active inputs
        step(1'b1, 8'h5A, 8'h5A, 8'h5A, 1'b0, "R9 reset");
        step(1'b1, 8'h11, 8'h22, 8'h33, 1'b0, "R9 reset");
        step(1'b1, 8'hFF, 8'hFF, 8'h00, 1'b1, "R9 reset");
        // R2: all equal
        step(1'b0, 8'hA5, 8'hA5, 8'hA5, 1'b0, "R2 all equal");
        step(1'b0, 8'h00, 8'h00, 8'h00, 1'b0, "R2 all zero");
        // R3: each pair
        step(1'b0, 8'h3C, 8'h3C, 8'h81, 1'b0, "R3 pair A-B / R7");
        step(1'b0, 8'h3C, 8'h7E, 8'h3C, 1'b0, "R3 pair A-C / R7");
        step(1'b0, 8'h01, 8'hC3, 8'hC3, 1'b0, "R3 pair B-C / R7");
        // R1: bitwise vote would give 11, word vote flags error
        step(1'b0, 8'h02, 8'h03, 8'h01, 1'b0, "R1 word compare");
        // R4 / R5 / R7: all differ
        step(1'b0, 8'h10, 8'h20, 8'h40, 1'b0, "R4 R5 R7 all differ");
        step(1'b0, 8'hFE, 8'hFD, 8'hFB, 1'b0, "R4 R5 all differ");
        // R6: complemented B
        step(1'b0, 8'h96, 8'h69, 8'h00, 1'b1, "R6 inv B matches A");
        step(1'b0, 8'h96, 8'h69, 8'h00, 1'b0, "R6 raw B no match");
        step(1'b0, 8'h44, 8'h44, 8'h12, 1'b1, "R6 raw equal becomes error");
        step(1'b0, 8'h44, 8'h44, 8'h12, 1'b0, "R6 raw equal passes");
        step(1'b0, 8'h07, 8'hF0, 8'h0F, 1'b1, "R6 inv B matches C");
        // R8: latency over held and changing inputs
        step(1'b0, 8'h5F, 8'h5F, 8'h00, 1'b0, "R8 hold");
        step(1'b0, 8'h5F, 8'h5F, 8'h00, 1'b0, "R8 hold");
        step(1'b0, 8'h01, 8'h02, 8'h03, 1'b0, "R8 change");
        // R9: mid-run reset
        step(1'b1, 8'h77, 8'h77, 8'h77, 1'b0, "R9 mid reset");
        // Random by pattern class
        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] a, b, c, bb;
            logic inv;
            int cls;
            a = W'($urandom);
            b = W'($urandom);
            c = W'($urandom);
            inv = 1'($urandom);
            cls = $urandom_range(0, 4);
            case (cls)
                0: begin b = a; c = a; end
                1: b = a;
                2: c = a;
                3: c = b;
                default: ;
            endcase
            bb = inv ? ~b : b;
            if (cls == 3) c = bb;
            if (cls != 3 && cls != 4) b = bb;
            // b above holds the aligned value for classes 0..2; re-encode for delivery
            if (cls != 3 && cls != 4) b = inv ? ~b : b;
            if (cls == 0 || cls == 1) b = inv ? ~a : a;
            step(1'b0, a, b, c, inv, "R2 R3 R4 R6 R7 random");
        end
        step(1'b0, 8'h00, 8'h00, 8'h00, 1'b0, "R2 tail");
        @(negedge clk);
        check_pending();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule